// File: doc/BRIEF.md
# Byte-wide fuse array read sequencer

This block reads a one-time-programmable fuse array one byte at a time in hardware, without a software loop that toggles pins and waits. A requester presents a start byte address and a byte count with a one-cycle `start` pulse. The sequencer then works through the read timing of the fuse macro on its control pins and delivers each byte on a valid/ready stream. After the last byte it puts the macro back into standby and pulses `done`.

All pin timing is built from one settle interval. It is a count of clock cycles derived from the `CLK_FREQ_HZ` parameter, so that it lasts one microsecond. The control pins leave the block as one packed control word, `fuse_ctrl`, and the 8-bit fuse output comes back on `fuse_dout`.

The state machine has these states:
- `ST_IDLE`: standby pins, waiting for `start`.
- `ST_INIT`: load and program enable high, chip select low, address zero, held for one interval.
- `ST_ADDR`: the byte address is applied for one interval.
- `ST_STRB`: strobe is high for one interval.
- `ST_SAMP`: strobe stays high and the captured byte is offered until it is accepted.
- `ST_DROP`: strobe is low for one interval.
- `ST_PARK`: standby pins and `done`, for one cycle.

The transitions are:
- `ST_IDLE` goes to `ST_INIT` on `start` with a nonzero count.
- `ST_IDLE` goes to `ST_PARK` on `start` with a zero count.
- `ST_INIT` goes to `ST_ADDR`, `ST_ADDR` goes to `ST_STRB` and `ST_STRB` goes to `ST_SAMP` when the interval ends.
- `ST_SAMP` goes to `ST_DROP` on `out_ready`.
- `ST_DROP` goes to `ST_ADDR` when the interval ends and bytes remain, and to `ST_PARK` when the interval ends after the last byte.
- `ST_PARK` goes to `ST_IDLE` unconditionally.

Top module: `fuse_rd_seq`

## Requirements
- R1: Out of reset and while idle, `fuse_ctrl` equals 0x0009. The bit layout of `fuse_ctrl` is: chip select at bit 0, strobe at bit 1, load at bit 2, program enable at bit 3, zeros at bits 4 and 5, and the 10-bit fuse address at bits 15:6.
- R2: When a transfer with a nonzero count starts, chip select falls and `fuse_ctrl` becomes 0x000C (load and program enable high, strobe low, address zero).
- R3: Each byte follows one fixed pattern: the address is held with strobe low for S cycles, then strobe is high for S cycles plus the cycles that `out_valid` is high, then strobe is low for S cycles. S is CLK_FREQ_HZ/1e6 and at least 1. Strobe falling at the start of one byte and rising for the next are therefore exactly 2S cycles apart, and so are chip select falling and the first strobe rise. The address does not change while strobe is high. `out_valid` is high only while strobe is high.
- R4: The address on the first strobe equals `start_addr`. Each later strobe uses the previous address plus one, modulo 1024, so 1023 is followed by 0.
- R5: Exactly `byte_count` strobes are issued and exactly `byte_count` bytes are delivered, in address order. Each byte equals the value that `fuse_dout` shows for its address while strobe is high.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `fuse_ctrl` stay unchanged in the next cycle.
- R7: S cycles after the last strobe falls, `fuse_ctrl` returns to 0x0009. `done` is high for exactly one cycle, while `fuse_ctrl` already reads 0x0009. In the cycle after `done`, `busy` is low.
- R8: A `start` pulse while `busy` is high has no effect on the running transfer.
- R9: A `start` with `byte_count` zero issues no strobe, keeps chip select high and raises `done` in the cycle after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a transfer; taken only while idle |
| start_addr | input | ADDR_W (10) | First fuse byte address |
| byte_count | input | COUNT_W (11) | Number of bytes to read |
| busy | output | 1 | High from the accepted start through the `done` cycle |
| done | output | 1 | One-cycle pulse once standby has been entered |
| out_data | output | DATA_W (8) | Captured fuse byte |
| out_valid | output | 1 | `out_data` holds a byte not yet accepted |
| out_ready | input | 1 | Consumer accepts `out_data` in this cycle |
| fuse_ctrl | output | ADDR_W+6 (16) | Packed fuse macro control word (see R1) |
| fuse_dout | input | DATA_W (8) | Data output of the fuse macro |

## Verification
The bench builds the block with CLK_FREQ_HZ set to 3 MHz, so the settle interval is 3 cycles. At that length every pin phase can be counted edge by edge, and many multi-byte transfers fit in a short run. The default 10-bit address and 11-bit count stay in place, so start addresses near 1023 reach the address wraparound. Random ready throttling stretches the strobe phase and exercises the stall hold. Zero counts and a start pulse in the middle of a transfer cover the paths that must leave the pins alone.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT,
        ST_ADDR,
        ST_STRB,
        ST_SAMP,
        ST_DROP,
        ST_PARK
    } seq_state_t;

    // positions inside the packed control word, decoded by the fuse macro
    localparam int BIT_CSB  = 0;
    localparam int BIT_STRB = 1;
    localparam int BIT_LOAD = 2;
    localparam int BIT_PGEN = 3;
    localparam int ADDR_LSB = 6;

    typedef struct packed {
        logic pgen;
        logic load;
        logic strb;
        logic csb;
    } pin_set_t;

endpackage

// File: rtl/fuse_rd_timer.sv
module fuse_rd_timer #(
    parameter int SETTLE_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SETTLE_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CNT_MAX;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/fuse_rd_cursor.sv
module fuse_rd_cursor #(
    parameter int ADDR_W  = 10,
    parameter int COUNT_W = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [ADDR_W-1:0]  load_addr,
    input  logic [COUNT_W-1:0] load_count,
    input  logic               step,
    output logic [ADDR_W-1:0]  addr,
    output logic               last
);
    logic [ADDR_W-1:0]  addr_q;
    logic [COUNT_W-1:0] rem_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            rem_q  <= '0;
        end else if (load) begin
            addr_q <= load_addr;
            rem_q  <= load_count;
        end else if (step) begin
            addr_q <= addr_q + 1'b1;
            rem_q  <= rem_q - 1'b1;
        end
    end

    assign addr = addr_q;
    assign last = (rem_q == COUNT_W'(1));

    AST_STEP_HAS_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (rem_q != '0)); // R5

endmodule

// File: rtl/fuse_rd_ctrl_word.sv
module fuse_rd_ctrl_word
    import fuse_rd_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  pin_set_t                   pins,
    input  logic [ADDR_W-1:0]          addr,
    output logic [ADDR_LSB+ADDR_W-1:0] word
);
    assign word[BIT_CSB]  = pins.csb;
    assign word[BIT_STRB] = pins.strb;
    assign word[BIT_LOAD] = pins.load;
    assign word[BIT_PGEN] = pins.pgen;
    assign word[ADDR_LSB +: ADDR_W] = addr;

    genvar gi;
    generate
        for (gi = BIT_PGEN + 1; gi < ADDR_LSB; gi++) begin : g_rsvd
            assign word[gi] = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/fuse_rd_seq.sv
module fuse_rd_seq
    import fuse_rd_pkg::*;
#(
    parameter int CLK_FREQ_HZ = 100_000_000,
    parameter int ADDR_W      = 10,
    parameter int COUNT_W     = 11,
    parameter int DATA_W      = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [ADDR_W-1:0]          start_addr,
    input  logic [COUNT_W-1:0]         byte_count,
    output logic                       busy,
    output logic                       done,
    output logic [DATA_W-1:0]          out_data,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [ADDR_LSB+ADDR_W-1:0] fuse_ctrl,
    input  logic [DATA_W-1:0]          fuse_dout
);
    localparam int US_CYC     = CLK_FREQ_HZ / 1_000_000;
    localparam int SETTLE_CYC = (US_CYC < 1) ? 1 : US_CYC;

    seq_state_t        st_q, st_d;
    logic              tmr_load, tmr_exp;
    logic              cur_load, cur_step, cur_last;
    logic [ADDR_W-1:0] cur_addr;
    logic              cap_en;
    logic [DATA_W-1:0] data_q;
    pin_set_t          pins;
    logic              addr_en;

    fuse_rd_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .expired (tmr_exp)
    );

    fuse_rd_cursor #(.ADDR_W(ADDR_W), .COUNT_W(COUNT_W)) u_cursor (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (cur_load),
        .load_addr  (start_addr),
        .load_count (byte_count),
        .step       (cur_step),
        .addr       (cur_addr),
        .last       (cur_last)
    );

    fuse_rd_ctrl_word #(.ADDR_W(ADDR_W)) u_word (
        .pins (pins),
        .addr (addr_en ? cur_addr : '0),
        .word (fuse_ctrl)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next state and sequencing strobes
    always_comb begin
        st_d     = st_q;
        tmr_load = 1'b0;
        cur_load = 1'b0;
        cur_step = 1'b0;
        cap_en   = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (start) begin
                    cur_load = 1'b1;
                    if (byte_count == '0) begin
                        st_d = ST_PARK;
                    end else begin
                        st_d     = ST_INIT;
                        tmr_load = 1'b1;
                    end
                end
            end
            ST_INIT: begin
                if (tmr_exp) begin
                    st_d     = ST_ADDR;
                    tmr_load = 1'b1;
                end
            end
            ST_ADDR: begin
                if (tmr_exp) begin
                    st_d     = ST_STRB;
                    tmr_load = 1'b1;
                end
            end
            ST_STRB: begin
                if (tmr_exp) begin
                    st_d   = ST_SAMP;
                    cap_en = 1'b1;
                end
            end
            ST_SAMP: begin
                if (out_ready) begin
                    st_d     = ST_DROP;
                    tmr_load = 1'b1;
                end
            end
            ST_DROP: begin
                if (tmr_exp) begin
                    cur_step = 1'b1;
                    if (cur_last) begin
                        st_d = ST_PARK;
                    end else begin
                        st_d     = ST_ADDR;
                        tmr_load = 1'b1;
                    end
                end
            end
            ST_PARK: begin
                st_d = ST_IDLE;
            end
            default: begin
                st_d = ST_IDLE;
            end
        endcase
    end

    // pin and handshake outputs decoded from the state
    always_comb begin
        pins    = '{pgen: 1'b1, load: 1'b0, strb: 1'b0, csb: 1'b1};
        addr_en = 1'b0;
        unique case (st_q)
            ST_IDLE, ST_PARK: begin
                pins = '{pgen: 1'b1, load: 1'b0, strb: 1'b0, csb: 1'b1};
            end
            ST_INIT: begin
                pins = '{pgen: 1'b1, load: 1'b1, strb: 1'b0, csb: 1'b0};
            end
            ST_ADDR, ST_DROP: begin
                pins    = '{pgen: 1'b1, load: 1'b1, strb: 1'b0, csb: 1'b0};
                addr_en = 1'b1;
            end
            ST_STRB, ST_SAMP: begin
                pins    = '{pgen: 1'b1, load: 1'b1, strb: 1'b1, csb: 1'b0};
                addr_en = 1'b1;
            end
            default: begin
                pins = '{pgen: 1'b1, load: 1'b0, strb: 1'b0, csb: 1'b1};
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (cap_en) begin
            data_q <= fuse_dout;
        end
    end

    assign busy      = (st_q != ST_IDLE);
    assign done      = (st_q == ST_PARK);
    assign out_valid = (st_q == ST_SAMP);
    assign out_data  = data_q;

    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(fuse_ctrl))); // R6
    AST_VALID_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (fuse_ctrl[BIT_STRB] && !fuse_ctrl[BIT_CSB])); // R3
    AST_STROBE_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fuse_ctrl[BIT_STRB] && $past(fuse_ctrl[BIT_STRB])) |-> $stable(fuse_ctrl[ADDR_LSB +: ADDR_W])); // R3
    AST_DONE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fuse_ctrl[BIT_CSB] && fuse_ctrl[BIT_PGEN] && !fuse_ctrl[BIT_LOAD] && !fuse_ctrl[BIT_STRB])); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_LOAD_WHILE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !fuse_ctrl[BIT_CSB] |-> (fuse_ctrl[BIT_LOAD] && fuse_ctrl[BIT_PGEN] && busy)); // R2

endmodule

// File: tb/sim_fuse_rd_seq.sv
module sim_fuse_rd_seq;
    localparam int CLK_PERIOD = 10;
    localparam int S = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [9:0]  start_addr = '0;
    logic [10:0] byte_count = '0;
    logic        out_ready = 1'b0;
    logic        busy, done, out_valid;
    logic [7:0]  out_data, fuse_dout;
    logic [15:0] fuse_ctrl;

    int n_chk = 0;
    int n_err = 0;

    wire       w_csb  = fuse_ctrl[0];
    wire       w_strb = fuse_ctrl[1];
    wire       w_load = fuse_ctrl[2];
    wire       w_pgen = fuse_ctrl[3];
    wire [9:0] w_addr = fuse_ctrl[15:6];

    function automatic logic [7:0] fuse_byte(input logic [9:0] a);
        logic [7:0] t;
        t = a[7:0] * 8'd37;
        return t ^ {6'b0, a[9:8]} ^ 8'h5C;
    endfunction

    // fuse macro model: answers only while strobe is high
    assign fuse_dout = w_strb ? fuse_byte(w_addr) : 8'hA5;

    fuse_rd_seq #(.CLK_FREQ_HZ(3_000_000)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .byte_count(byte_count), .busy(busy), .done(done), .out_data(out_data),
        .out_valid(out_valid), .out_ready(out_ready), .fuse_ctrl(fuse_ctrl),
        .fuse_dout(fuse_dout)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // pin timing monitor
    logic       m_prev_strb = 1'b0;
    logic       m_prev_csb  = 1'b1;
    int         low_run = 0, hi_run = 0, vcnt = 0, m_rises = 0;
    logic [9:0] m_addr = '0;

    always @(negedge clk) begin
        #3;
        if (rst_n) begin
            if (w_strb && !m_prev_strb) begin
                check(low_run == 2*S, "R3", "strobe-low gap", low_run, 2*S);
                check(w_addr == m_addr, "R4", "strobe address", w_addr, m_addr);
                m_addr  = m_addr + 10'd1;
                m_rises = m_rises + 1;
                hi_run  = 0;
                vcnt    = 0;
                low_run = 0;
            end
            if (!w_strb && m_prev_strb) begin
                check(hi_run == S + vcnt && vcnt >= 1, "R3", "strobe width", hi_run, S + vcnt);
                low_run = 0;
            end
            if (w_csb && !m_prev_csb) begin
                check(low_run == S, "R7", "tail settle", low_run, S);
            end
            if (!w_csb && m_prev_csb) begin
                check(fuse_ctrl == 16'h000C, "R2", "init word", fuse_ctrl, 16'h000C);
                low_run = 0;
            end
            if (!w_csb && !w_strb) low_run = low_run + 1;
            if (w_strb) begin
                hi_run = hi_run + 1;
                if (out_valid) vcnt = vcnt + 1;
            end
            m_prev_strb = w_strb;
            m_prev_csb  = w_csb;
        end
    end

    task automatic xfer(input logic [9:0] off, input int n, input int rdy_pct, input bit inject);
        int         got = 0;
        int         cyc = 0;
        bit         seen_done = 0;
        bit         stall = 0;
        logic [7:0] pdata = '0;
        logic [15:0] pctrl = '0;
        logic [7:0] expb;
        @(negedge clk);
        start      = 1'b1;
        start_addr = off;
        byte_count = 11'(n);
        m_addr     = off;
        m_rises    = 0;
        @(negedge clk);
        start = 1'b0;
        while (!seen_done && cyc < 5000) begin
            out_ready = ($urandom_range(99) < rdy_pct);
            if (inject && cyc == 4) begin
                start      = 1'b1;
                start_addr = off + 10'd100;
                byte_count = 11'd5;
            end else begin
                start = 1'b0;
            end
            #1;
            if (inject && cyc == 4) check(busy, "R8", "busy at restart attempt", busy, 1);
            if (stall) check(out_valid && out_data == pdata && fuse_ctrl == pctrl,
                             "R6", "stall hold", out_data, pdata);
            if (out_valid && out_ready) begin
                expb = fuse_byte(10'(off + 10'(got)));
                check(out_data == expb, inject ? "R8" : "R5", "byte value", out_data, expb);
                got++;
            end
            stall = out_valid && !out_ready;
            pdata = out_data;
            pctrl = fuse_ctrl;
            if (done) begin
                seen_done = 1;
                check(fuse_ctrl == 16'h0009, "R7", "standby at done", fuse_ctrl, 16'h0009);
                if (n == 0) check(cyc == 0, "R9", "zero-count done cycle", cyc, 0);
            end
            cyc++;
            @(negedge clk);
        end
        start     = 1'b0;
        out_ready = 1'b0;
        check(seen_done, "R7", "done seen", seen_done, 1);
        check(got == n, inject ? "R8" : "R5", "byte count", got, n);
        check(m_rises == n, (n == 0) ? "R9" : "R5", "strobe count", m_rises, n);
        #1;
        check(!done && !busy, "R7", "idle after done", {done, busy}, 0);
        check(fuse_ctrl == 16'h0009, "R1", "idle word", fuse_ctrl, 16'h0009);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check(fuse_ctrl == 16'h0009, "R1", "reset word", fuse_ctrl, 16'h0009);
        check(!busy && !done && !out_valid, "R1", "reset flags", {busy, done, out_valid}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(fuse_ctrl == 16'h0009, "R1", "idle after reset", fuse_ctrl, 16'h0009);

        xfer(10'd5, 4, 100, 0);
        xfer(10'd1022, 4, 100, 0);   // R4 wrap 1023 -> 0
        xfer(10'd0, 0, 100, 0);      // R9
        xfer(10'd0, 3, 30, 0);       // R6 back-pressure
        xfer(10'd17, 6, 60, 1);      // R8 start while busy
        xfer(10'd1023, 1, 20, 0);
        xfer(10'd700, 0, 50, 0);     // R9 again
        for (int i = 0; i < 8; i++) begin
            xfer(10'($urandom_range(1023)), $urandom_range(7), $urandom_range(100, 20), 0);
        end
        finish_run();
    end

endmodule